// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor core's status logic and decides which exception, if any, the core takes in a given cycle. Seven request lines arrive together: reset request, data abort, fast interrupt (FIQ), normal interrupt (IRQ), prefetch abort, undefined instruction and software interrupt. The two interrupt lines are gated by the disable bits of the current status word. The block picks the surviving request with the highest fixed priority and computes the handler address from a low or high vector base. It also computes the status word the core continues with, and it records the return address and the old status word in a saved-state slot that belongs to the exception's target mode.

The same slots serve a return-from-exception command. When the core asks to return, the block looks up the slot of the mode named in the current status word. It hands back the saved status word and the saved return address as the new status word and program counter. All results are registered and appear one clock after the inputs that caused them.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among unmasked requests, exactly one is taken per cycle, in the fixed order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt (highest first). `exc_code` reports the taken one: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7.
- R2: If undefined instruction and software interrupt are requested together, undefined is taken (code 1).
- R3: With `hivec_sel` low, `pc_out` equals `exc_code` times 4 on an exception (offsets 0x00 to 0x1C; 0x14 is never produced).
- R4: With `hivec_sel` high, `pc_out` equals 0xFFFF0000 plus `exc_code` times 4.
- R5: The mode field (status bits 4:0) of `psr_out` is set to the target mode. Reset and software interrupt go to supervisor (0x13). Both aborts go to abort (0x17). Undefined goes to 0x1B, IRQ to 0x12 and FIQ to 0x11.
- R6: On entry, `psr_out` is the current status word with bit 5 (instruction-set state) cleared and bit 7 (IRQ disable) set. Bit 6 (FIQ disable) is also set for reset and FIQ; for other exceptions bit 6 keeps its value. All other bits are carried over.
- R7: On entry, `save_we` pulses, `save_mode` gives the target mode, `save_lr` gives `cur_pc` and `save_psr` gives `cur_psr`. The slot of that mode is updated with those two values.
- R8: An IRQ request is ignored while `cur_psr` bit 7 is 1, and an FIQ request is ignored while bit 6 is 1. A lower request is taken instead, or none.
- R9: A return request taken while `cur_psr[4:0]` names an exception mode drives `ret_done`. It also drives `psr_out` with that mode's saved status word and `pc_out` with its saved return address.
- R10: A return request in user (0x10) or system (0x1F) mode has no effect. No output flag rises, and no saved slot changes.
- R11: A return request in the same cycle as an accepted exception is dropped; only the exception is performed.
- R12: After reset, and in any cycle without an event, all flags and data outputs are 0.
- R13: The reset request is level-sensitive. It is taken in every cycle it is high, whatever the other requests and the disable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_reset | input | 1 | Reset exception request (level) |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| hivec_sel | input | 1 | Selects the high vector base |
| cur_psr | input | DATA_W | Current status word |
| cur_pc | input | DATA_W | Return address to save on entry |
| ret_req | input | 1 | Return-from-exception command |
| exc_vld | output | 1 | An exception was taken |
| exc_code | output | 3 | Code of the taken exception |
| ret_done | output | 1 | A return was performed |
| pc_out | output | DATA_W | New program counter |
| psr_out | output | DATA_W | New status word |
| save_we | output | 1 | Saved-state write strobe |
| save_mode | output | 5 | Mode whose slot is written |
| save_lr | output | DATA_W | Return address written |
| save_psr | output | DATA_W | Status word written |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. This covers the flags, code, new PC and status word, and the saved-state write. The bench drives inputs on the falling edge and samples one time unit after the next rising edge, so each check sees the first registered result of its stimulus. A return reads a slot written by an earlier entry, so the bench always places the entry at least one edge before the return that reads it. It then checks the returned values in the cycle after the return edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_BANKS = 5;
  localparam int BANK_IW   = $clog2(NUM_BANKS);
  localparam int CODE_W    = 3;
  localparam int MODE_W    = 5;

  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;

  localparam logic [CODE_W-1:0] EXC_RST  = 3'd0;
  localparam logic [CODE_W-1:0] EXC_UND  = 3'd1;
  localparam logic [CODE_W-1:0] EXC_SWI  = 3'd2;
  localparam logic [CODE_W-1:0] EXC_PABT = 3'd3;
  localparam logic [CODE_W-1:0] EXC_DABT = 3'd4;
  localparam logic [CODE_W-1:0] EXC_IRQ  = 3'd6;
  localparam logic [CODE_W-1:0] EXC_FIQ  = 3'd7;

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  // request vector index (0 = lowest priority) to exception code
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      0:       return EXC_SWI;
      1:       return EXC_UND;
      2:       return EXC_PABT;
      3:       return EXC_IRQ;
      4:       return EXC_FIQ;
      5:       return EXC_DABT;
      default: return EXC_RST;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] code_to_mode(input logic [CODE_W-1:0] code);
    case (code)
      EXC_UND:           return MD_UND;
      EXC_PABT, EXC_DABT: return MD_ABT;
      EXC_IRQ:           return MD_IRQ;
      EXC_FIQ:           return MD_FIQ;
      default:           return MD_SVC;
    endcase
  endfunction

  // {hit, slot index}; user and system modes own no slot
  function automatic logic [BANK_IW:0] mode_to_bank(input logic [MODE_W-1:0] mode);
    case (mode)
      MD_FIQ:  return {1'b1, BANK_IW'(0)};
      MD_IRQ:  return {1'b1, BANK_IW'(1)};
      MD_SVC:  return {1'b1, BANK_IW'(2)};
      MD_ABT:  return {1'b1, BANK_IW'(3)};
      MD_UND:  return {1'b1, BANK_IW'(4)};
      default: return {1'b0, BANK_IW'(0)};
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  // highest index wins: later loop iterations overwrite earlier ones
  always_comb begin
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
  import exc_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [NUM_SRC-1:0] gnt_i,
  input  logic               hivec_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               fmask_o,
  output logic [DATA_W-1:0]  vec_o,
  output logic [BANK_IW-1:0] bank_o
);
  logic [BANK_IW:0]  bank_full;
  logic [DATA_W-1:0] base;

  always_comb begin
    code_o = EXC_RST;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gnt_i[i]) code_o = src_code(i);
    end
    mode_o    = code_to_mode(code_o);
    fmask_o   = (code_o == EXC_RST) || (code_o == EXC_FIQ);
    base      = hivec_i ? HI_BASE : '0;
    vec_o     = base | DATA_W'({code_o, 2'b00});
    bank_full = mode_to_bank(mode_o);
    bank_o    = bank_full[BANK_IW-1:0];
  end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int DATA_W = 32,
  parameter int NUM_B  = 5,
  localparam int IW    = $clog2(NUM_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0] wr_psr_i,
  input  logic [DATA_W-1:0] wr_lr_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_psr_o,
  output logic [DATA_W-1:0] rd_lr_o
);
  logic [DATA_W-1:0] slot_psr [NUM_B];
  logic [DATA_W-1:0] slot_lr  [NUM_B];

  for (genvar b = 0; b < NUM_B; b++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] psr_q;
    logic [DATA_W-1:0] lr_q;

    assign en = we_i && (wr_idx_i == IW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        psr_q <= '0;
        lr_q  <= '0;
      end else if (en) begin
        psr_q <= wr_psr_i;
        lr_q  <= wr_lr_i;
      end
    end

    assign slot_psr[b] = psr_q;
    assign slot_lr[b]  = lr_q;
  end

  always_comb begin
    rd_psr_o = '0;
    rd_lr_o  = '0;
    for (int b = 0; b < NUM_B; b++) begin
      if (rd_idx_i == IW'(b)) begin
        rd_psr_o = slot_psr[b];
        rd_lr_o  = slot_lr[b];
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic              hivec_sel,
  input  logic [DATA_W-1:0] cur_psr,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic              ret_req,
  output logic              exc_vld,
  output logic [2:0]        exc_code,
  output logic              ret_done,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] psr_out,
  output logic              save_we,
  output logic [4:0]        save_mode,
  output logic [DATA_W-1:0] save_lr,
  output logic [DATA_W-1:0] save_psr
);
  // ---------------- request masking and selection ----------------
  logic [NUM_SRC-1:0] req_vec;
  logic [NUM_SRC-1:0] gnt;
  logic               any_exc;

  assign req_vec = {req_reset,
                    req_dabt,
                    req_fiq & ~cur_psr[PSR_F],
                    req_irq & ~cur_psr[PSR_I],
                    req_pabt,
                    req_und,
                    req_swi};

  exc_prio_pick #(.N(NUM_SRC)) i_pick (
    .req_i (req_vec),
    .gnt_o (gnt),
    .any_o (any_exc)
  );

  logic [CODE_W-1:0]  tgt_code;
  logic [MODE_W-1:0]  tgt_mode;
  logic               tgt_fmask;
  logic [DATA_W-1:0]  tgt_vec;
  logic [BANK_IW-1:0] tgt_bank;

  exc_vec_map #(.DATA_W(DATA_W), .HI_BASE(HI_BASE)) i_map (
    .gnt_i   (gnt),
    .hivec_i (hivec_sel),
    .code_o  (tgt_code),
    .mode_o  (tgt_mode),
    .fmask_o (tgt_fmask),
    .vec_o   (tgt_vec),
    .bank_o  (tgt_bank)
  );

  // ---------------- saved-state slots ----------------
  logic [BANK_IW:0]   cur_bank;
  logic               cur_hit;
  logic [BANK_IW-1:0] cur_idx;
  logic [DATA_W-1:0]  rd_psr;
  logic [DATA_W-1:0]  rd_lr;

  assign cur_bank = mode_to_bank(cur_psr[MODE_W-1:0]);
  assign cur_hit  = cur_bank[BANK_IW];
  assign cur_idx  = cur_bank[BANK_IW-1:0];

  exc_save_bank #(.DATA_W(DATA_W), .NUM_B(NUM_BANKS)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (any_exc),
    .wr_idx_i (tgt_bank),
    .wr_psr_i (cur_psr),
    .wr_lr_i  (cur_pc),
    .rd_idx_i (cur_idx),
    .rd_psr_o (rd_psr),
    .rd_lr_o  (rd_lr)
  );

  // ---------------- next-state logic ----------------
  logic               take_ret;
  logic [DATA_W-1:0]  entry_psr;
  logic               exc_vld_d, ret_done_d, save_we_d;
  logic [CODE_W-1:0]  exc_code_d;
  logic [DATA_W-1:0]  pc_d, psr_d, save_lr_d, save_psr_d;
  logic [MODE_W-1:0]  save_mode_d;

  assign take_ret = ret_req && !any_exc && cur_hit;

  always_comb begin
    entry_psr                   = cur_psr;
    entry_psr[MODE_W-1:0]       = tgt_mode;
    entry_psr[PSR_T]            = 1'b0;
    entry_psr[PSR_I]            = 1'b1;
    if (tgt_fmask) entry_psr[PSR_F] = 1'b1;

    exc_vld_d   = any_exc;
    ret_done_d  = take_ret;
    exc_code_d  = any_exc ? tgt_code : '0;
    save_we_d   = any_exc;
    save_mode_d = any_exc ? tgt_mode : '0;
    save_lr_d   = any_exc ? cur_pc   : '0;
    save_psr_d  = any_exc ? cur_psr  : '0;

    if (any_exc) begin
      pc_d  = tgt_vec;
      psr_d = entry_psr;
    end else if (take_ret) begin
      pc_d  = rd_lr;
      psr_d = rd_psr;
    end else begin
      pc_d  = '0;
      psr_d = '0;
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_vld   <= 1'b0;
      exc_code  <= '0;
      ret_done  <= 1'b0;
      pc_out    <= '0;
      psr_out   <= '0;
      save_we   <= 1'b0;
      save_mode <= '0;
      save_lr   <= '0;
      save_psr  <= '0;
    end else begin
      exc_vld   <= exc_vld_d;
      exc_code  <= exc_code_d;
      ret_done  <= ret_done_d;
      pc_out    <= pc_d;
      psr_out   <= psr_d;
      save_we   <= save_we_d;
      save_mode <= save_mode_d;
      save_lr   <= save_lr_d;
      save_psr  <= save_psr_d;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_reset,
  input logic              hivec_sel,
  input logic [DATA_W-1:0] cur_psr,
  input logic              exc_vld,
  input logic [2:0]        exc_code,
  input logic              ret_done,
  input logic [DATA_W-1:0] pc_out,
  input logic [DATA_W-1:0] psr_out,
  input logic              save_we,
  input logic [4:0]        save_mode
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_vld && ret_done)); // R11

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_reset |=> (exc_vld && exc_code == 3'd0)); // R13

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> ((pc_out & ~DATA_W'(32'h1F)) == ($past(hivec_sel) ? HI_BASE : '0))); // R4

  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (pc_out[4:0] == {exc_code, 2'b00})); // R3

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (!psr_out[5] && psr_out[7])); // R6

  AST_SAVE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (save_we && save_mode == psr_out[4:0])); // R7

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_code == 3'd6) |-> !$past(cur_psr[7])); // R8

  AST_FIQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_code == 3'd7) |-> !$past(cur_psr[6])); // R8

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (exc_code != 3'd5)); // R1
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DATA_W(DATA_W), .HI_BASE(HI_BASE)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_reset (req_reset),
  .hivec_sel (hivec_sel),
  .cur_psr   (cur_psr),
  .exc_vld   (exc_vld),
  .exc_code  (exc_code),
  .ret_done  (ret_done),
  .pc_out    (pc_out),
  .psr_out   (psr_out),
  .save_we   (save_we),
  .save_mode (save_mode)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_reset, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi;
  logic        hivec_sel, ret_req;
  logic [31:0] cur_psr, cur_pc;
  logic        exc_vld, ret_done, save_we;
  logic [2:0]  exc_code;
  logic [31:0] pc_out, psr_out, save_lr, save_psr;
  logic [4:0]  save_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk, .rst_n, .req_reset, .req_dabt, .req_fiq, .req_irq, .req_pabt,
    .req_und, .req_swi, .hivec_sel, .cur_psr, .cur_pc, .ret_req,
    .exc_vld, .exc_code, .ret_done, .pc_out, .psr_out,
    .save_we, .save_mode, .save_lr, .save_psr
  );

  // req bits: [6] reset [5] dabt [4] fiq [3] irq [2] pabt [1] und [0] swi
  typedef struct packed {
    logic [6:0] req;
    logic [7:0] psr;
    logic       hiv;
    logic       vld;
    logic [2:0] code;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'b0000001, 8'h10, 1'b0, 1'b1, 3'd2},
    '{7'b0000010, 8'h10, 1'b0, 1'b1, 3'd1},
    '{7'b0000011, 8'h10, 1'b0, 1'b1, 3'd1},
    '{7'b0000100, 8'h30, 1'b0, 1'b1, 3'd3},
    '{7'b0000111, 8'h10, 1'b0, 1'b1, 3'd3},
    '{7'b0001100, 8'h10, 1'b0, 1'b1, 3'd6},
    '{7'b0001100, 8'h90, 1'b0, 1'b1, 3'd3},
    '{7'b0011000, 8'h10, 1'b0, 1'b1, 3'd7},
    '{7'b0011000, 8'h50, 1'b0, 1'b1, 3'd6},
    '{7'b0011000, 8'hD0, 1'b0, 1'b0, 3'd0},
    '{7'b0111111, 8'h10, 1'b0, 1'b1, 3'd4},
    '{7'b1111111, 8'hD0, 1'b1, 1'b1, 3'd0},
    '{7'b0001000, 8'h13, 1'b1, 1'b1, 3'd6},
    '{7'b0010000, 8'h1F, 1'b1, 1'b1, 3'd7},
    '{7'b0000000, 8'h10, 1'b0, 1'b0, 3'd0},
    '{7'b1000000, 8'hD3, 1'b0, 1'b1, 3'd0}
  };

  function automatic logic [4:0] exp_mode(input logic [2:0] c);
    case (c)
      3'd1:       return 5'h1B;
      3'd3, 3'd4: return 5'h17;
      3'd6:       return 5'h12;
      3'd7:       return 5'h11;
      default:    return 5'h13;
    endcase
  endfunction

  function automatic logic [31:0] exp_psr(input logic [2:0] c, input logic [31:0] p);
    logic [31:0] r;
    r = p;
    r[4:0] = exp_mode(c);
    r[5] = 1'b0;
    r[7] = 1'b1;
    if (c == 3'd0 || c == 3'd7) r[6] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic [31:0] p, input logic [31:0] pc,
                       input logic hv, input logic rt);
    @(negedge clk);
    {req_reset, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi} = r;
    cur_psr = p; cur_pc = pc; hivec_sel = hv; ret_req = rt;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(7'b0, 32'h10, 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {req_reset, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi} = '0;
    hivec_sel = 1'b0; ret_req = 1'b0; cur_psr = 32'h10; cur_pc = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12 exc_vld", 32'(exc_vld), 32'd0);
    chk("R12 pc_out", pc_out, 32'd0);
    chk("R12 psr_out", psr_out, 32'd0);
    chk("R12 save_we", 32'(save_we), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] p, pc, epc;
      p  = 32'hF000_0000 | 32'(VECS[i].psr);
      pc = 32'h0000_1000 + 32'(i) * 4;
      drive(VECS[i].req, p, pc, VECS[i].hiv, 1'b0);
      chk("R8 exc_vld", 32'(exc_vld), 32'(VECS[i].vld));
      if (VECS[i].vld) begin
        epc = (VECS[i].hiv ? 32'hFFFF_0000 : 32'h0) + 32'(VECS[i].code) * 4;
        chk("R1 exc_code", 32'(exc_code), 32'(VECS[i].code));
        chk(VECS[i].hiv ? "R4 pc_out" : "R3 pc_out", pc_out, epc);
        chk("R5 mode", 32'(psr_out[4:0]), 32'(exp_mode(VECS[i].code)));
        chk("R6 psr_out", psr_out, exp_psr(VECS[i].code, p));
        chk("R7 save_mode", 32'(save_mode), 32'(exp_mode(VECS[i].code)));
        chk("R7 save_lr", save_lr, pc);
        chk("R7 save_psr", save_psr, p);
      end else begin
        chk("R12 idle pc_out", pc_out, 32'd0);
        chk("R12 idle save_we", 32'(save_we), 32'd0);
      end
    end

    // R2 explicit: und and swi together
    drive(7'b0000011, 32'h10, 32'h44, 1'b0, 1'b0);
    chk("R2 exc_code", 32'(exc_code), 32'd1);

    // R9: IRQ entry then return
    drive(7'b0001000, 32'h2000_0010, 32'h8000_0040, 1'b0, 1'b0);
    chk("R9 entry vld", 32'(exc_vld), 32'd1);
    drive(7'b0, 32'h2000_0092, 32'h0, 1'b0, 1'b1);
    chk("R9 ret_done", 32'(ret_done), 32'd1);
    chk("R9 psr_out", psr_out, 32'h2000_0010);
    chk("R9 pc_out", pc_out, 32'h8000_0040);

    // R10: return in user and system mode has no effect
    drive(7'b0, 32'h0000_0010, 32'h0, 1'b0, 1'b1);
    chk("R10 ret_done usr", 32'(ret_done), 32'd0);
    chk("R10 pc_out usr", pc_out, 32'd0);
    drive(7'b0, 32'h0000_001F, 32'h0, 1'b0, 1'b1);
    chk("R10 ret_done sys", 32'(ret_done), 32'd0);
    chk("R10 exc_vld sys", 32'(exc_vld), 32'd0);
    drive(7'b0, 32'h2000_0092, 32'h0, 1'b0, 1'b1);
    chk("R10 slot kept", pc_out, 32'h8000_0040);

    // R11: return dropped when an exception arrives together
    drive(7'b0000001, 32'h0000_0092, 32'h0000_0500, 1'b0, 1'b1);
    chk("R11 exc_vld", 32'(exc_vld), 32'd1);
    chk("R11 exc_code", 32'(exc_code), 32'd2);
    chk("R11 ret_done", 32'(ret_done), 32'd0);
    drive(7'b0, 32'h0000_00D3, 32'h0, 1'b0, 1'b1);
    chk("R9 svc psr_out", psr_out, 32'h0000_0092);
    chk("R9 svc pc_out", pc_out, 32'h0000_0500);

    // R13: reset request held for several cycles
    for (int k = 0; k < 3; k++) begin
      drive(7'b1111111, 32'h0000_00D1, 32'h0, 1'b1, 1'b1);
      chk("R13 exc_vld", 32'(exc_vld), 32'd1);
      chk("R13 exc_code", 32'(exc_code), 32'd0);
      chk("R13 pc_out", pc_out, 32'hFFFF_0000);
    end
    idle();
    chk("R12 idle after", 32'(exc_vld | ret_done | save_we), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule